// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Programming Sequencer

This block drives the programming of a one-time-programmable memory of 2^ADDR_W words (65,536 words of 16 bits by default) from a stream of data words supplied by a host. After a start strobe it switches on the raised core supply and the programming supply, waits for them to settle, and then sweeps the address space three times. The first sweep gives each word a single program pulse with no check. The second sweep reads each word back and, when the read disagrees with the intended data, applies another pulse and reads again, up to MAX_RETRY extra pulses per word. The third sweep runs with both supply enables off and compares every word once more to decide the final result.

The host is asked for the word at each address through a request/valid handshake on every sweep and must return the same value each time. All timing on the device side (pulse width, supply settling, recovery before a read, read access) is counted in clock cycles through parameters, so 100 us of pulse at the system clock becomes PULSE_CYC. When the run ends, `done` rises together with `pass`, and `fail_addr` names the first address that failed either in the retry loop or in the final compare.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, and while idle, busy, done, pass, host_req, dev_pgm, dev_oe, vcc_prog_en and vpp_en are all 0.
- R2: A start pulse while idle sets busy on the next cycle, clears done and pass, raises vcc_prog_en and vpp_en, and holds host_req low for exactly SETTLE_CYC cycles before the first word request.
- R3: Every program pulse is a run of exactly PULSE_CYC consecutive cycles of dev_pgm = 1, occurs only while vcc_prog_en and vpp_en are both 1, never overlaps dev_oe, and drives dev_wdata equal to the host word for dev_addr.
- R4: The first sweep requests addresses 0 to the last in ascending order and applies exactly one pulse per address with no read.
- R5: The second sweep requests the addresses again in ascending order; each word is read after RECOV_CYC cycles with dev_oe low, by holding dev_oe high for READ_CYC cycles and comparing dev_rdata on the last of them; a mismatch triggers another pulse, up to MAX_RETRY extra pulses per word.
- R6: A word that still mismatches after MAX_RETRY extra pulses ends the run: no further address is requested, both supply enables drop, and done = 1 with pass = 0 and fail_addr = that address.
- R7: After the whole second sweep matches, both supply enables go to 0, SETTLE_CYC cycles pass, and a third sweep reads every word with the supply enables off; the first mismatch ends the run with done = 1, pass = 0 and fail_addr = that address.
- R8: When every word of the third sweep matches, done = 1 and pass = 1; done is never 1 while busy is 1.
- R9: host_req holds host_addr stable until host_valid is 1; a word is taken only in a cycle with host_req and host_valid both 1, so any number of stall cycles is tolerated.
- R10: A new start after a finished run clears done and pass and repeats the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, taken while idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Run result, valid while done is 1 |
| fail_addr | output | ADDR_W | First failing address, valid when done is 1 and pass is 0 |
| host_req | output | 1 | Request for the word at host_addr |
| host_addr | output | ADDR_W | Address of the requested word |
| host_valid | input | 1 | host_data carries the requested word |
| host_data | input | DATA_W | Word from the host |
| dev_addr | output | ADDR_W | Device address pins |
| dev_wdata | output | DATA_W | Data driven to the device while programming |
| dev_rdata | input | DATA_W | Data read from the device |
| dev_oe | output | 1 | Device output enable, active high |
| dev_pgm | output | 1 | Program pulse, active high |
| vcc_prog_en | output | 1 | Raise the core supply to its programming level |
| vpp_en | output | 1 | Switch on the programming supply |

## Verification
The bench models the memory with a per-address count of pulses a word needs before it holds its data, so it can place a word that needs exactly the retry limit and one that needs a single pulse more; a design with an off-by-one in the retry count would fail the first or pass the second. A model that corrupts one word only when the supplies are low exposes a design that skips the final sweep or runs it with the supplies still raised, since it would report pass. A host that stalls each request shows whether the sequencer takes a word before host_valid or lets the address move, which would program wrong data, and measured pulse runs catch a pulse one cycle too long or too short.

// File: rtl/eprom_seq_pkg.sv
// Shared types for the programming sequencer.
// Assumes nothing beyond SystemVerilog enum support.
package eprom_seq_pkg;

    // Sequencer states: three sweeps plus supply transitions.
    typedef enum logic [3:0] {
        S_IDLE,
        S_RAISE,
        S_P1_FETCH,
        S_P1_PULSE,
        S_P2_FETCH,
        S_P2_RECOV,
        S_P2_READ,
        S_P2_PULSE,
        S_LOWER,
        S_P3_FETCH,
        S_P3_READ,
        S_ABORT
    } seq_state_t;

endpackage

// File: rtl/eprom_seq_timer.sv
// Down-counting interval timer.
// A load sets the count to (interval - 1); the count then falls to zero and
// holds there, so a state entered with a load lasts exactly the interval.
// Assumes every interval loaded is at least one cycle.
module eprom_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eprom_seq_word.sv
// Holds the word taken from the host for the current address and
// compares it with the device read data.
// Assumes the caller captures exactly once per address per sweep.
module eprom_seq_word #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] host_word,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] word,
    output logic              match
);

    logic [DATA_W-1:0] word_q;

    // Capture the host word on an accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (capture)
            word_q <= host_word;
    end

    assign word  = word_q;
    assign match = (rd_word == word_q);

endmodule

// File: rtl/eprom_prog_seq.sv
// Programming sequencer for a one-time-programmable word memory.
// Sweep 1 pulses each word once; sweep 2 verifies and re-pulses up to
// MAX_RETRY times; sweep 3 compares all words with the supplies lowered.
// Assumes the host returns the same word for an address on every sweep and
// that all cycle-count parameters are at least 1.
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 25000,
    parameter int SETTLE_CYC = 2500,
    parameter int RECOV_CYC  = 250,
    parameter int READ_CYC   = 16,
    parameter int MAX_RETRY  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              host_req,
    output logic [ADDR_W-1:0] host_addr,
    input  logic              host_valid,
    input  logic [DATA_W-1:0] host_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_oe,
    output logic              dev_pgm,
    output logic              vcc_prog_en,
    output logic              vpp_en
);

    localparam int T_A   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int T_B   = (RECOV_CYC > READ_CYC) ? RECOV_CYC : READ_CYC;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [RTY_W-1:0]  retry_q;
    logic              done_q, pass_q;
    logic [ADDR_W-1:0] fail_q;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              take_word, word_match, last_addr, retry_full;

    assign take_word  = host_req && host_valid;
    assign last_addr  = (addr_q == LAST_ADDR);
    assign retry_full = (retry_q == RTY_W'(MAX_RETRY));

    eprom_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eprom_seq_word #(.DATA_W(DATA_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (take_word),
        .host_word (host_data),
        .rd_word   (dev_rdata),
        .word      (dev_wdata),
        .match     (word_match)
    );

    // Next-state selection across the three sweeps.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:     if (start)      state_d = S_RAISE;
            S_RAISE:    if (tmr_zero)   state_d = S_P1_FETCH;
            S_P1_FETCH: if (host_valid) state_d = S_P1_PULSE;
            S_P1_PULSE: if (tmr_zero)   state_d = last_addr ? S_P2_FETCH : S_P1_FETCH;
            S_P2_FETCH: if (host_valid) state_d = S_P2_RECOV;
            S_P2_RECOV: if (tmr_zero)   state_d = S_P2_READ;
            S_P2_READ:
                if (tmr_zero) begin
                    if (word_match)      state_d = last_addr ? S_LOWER : S_P2_FETCH;
                    else if (retry_full) state_d = S_ABORT;
                    else                 state_d = S_P2_PULSE;
                end
            S_P2_PULSE: if (tmr_zero)   state_d = S_P2_RECOV;
            S_LOWER:    if (tmr_zero)   state_d = S_P3_FETCH;
            S_P3_FETCH: if (host_valid) state_d = S_P3_READ;
            S_P3_READ:
                if (tmr_zero)
                    state_d = (!word_match || last_addr) ? S_IDLE : S_P3_FETCH;
            S_ABORT:    if (tmr_zero)   state_d = S_IDLE;
            default:                    state_d = S_IDLE;
        endcase
    end

    // Interval for the timed state being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_RAISE, S_LOWER, S_ABORT: tmr_val = CNT_W'(SETTLE_CYC - 1);
            S_P1_PULSE, S_P2_PULSE:    tmr_val = CNT_W'(PULSE_CYC - 1);
            S_P2_RECOV:                tmr_val = CNT_W'(RECOV_CYC - 1);
            S_P2_READ, S_P3_READ:      tmr_val = CNT_W'(READ_CYC - 1);
            default:                   tmr_val = '0;
        endcase
    end

    // State, address and retry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                S_IDLE:     addr_q <= '0;
                S_P1_PULSE: if (tmr_zero) addr_q <= addr_q + 1'b1;
                S_P2_FETCH: retry_q <= '0;
                S_P2_READ:
                    if (tmr_zero) begin
                        if (word_match)       addr_q  <= addr_q + 1'b1;
                        else if (!retry_full) retry_q <= retry_q + 1'b1;
                    end
                S_P3_READ:
                    if (tmr_zero && word_match && !last_addr)
                        addr_q <= addr_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Result registers: cleared on start, set when a run ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            case (state_q)
                S_IDLE:
                    if (start) begin
                        done_q <= 1'b0;
                        pass_q <= 1'b0;
                        fail_q <= '0;
                    end
                S_P2_READ:
                    if (tmr_zero && !word_match && retry_full)
                        fail_q <= addr_q;
                S_ABORT:
                    if (tmr_zero) done_q <= 1'b1;
                S_P3_READ:
                    if (tmr_zero) begin
                        if (!word_match) begin
                            fail_q <= addr_q;
                            done_q <= 1'b1;
                        end else if (last_addr) begin
                            pass_q <= 1'b1;
                            done_q <= 1'b1;
                        end
                    end
                default: ;
            endcase
        end
    end

    // Pin and status decode from the registered state.
    always_comb begin
        busy        = (state_q != S_IDLE);
        host_req    = (state_q == S_P1_FETCH) || (state_q == S_P2_FETCH) ||
                      (state_q == S_P3_FETCH);
        dev_pgm     = (state_q == S_P1_PULSE) || (state_q == S_P2_PULSE);
        dev_oe      = (state_q == S_P2_READ) || (state_q == S_P3_READ);
        vcc_prog_en = (state_q == S_RAISE) || (state_q == S_P1_FETCH) ||
                      (state_q == S_P1_PULSE) || (state_q == S_P2_FETCH) ||
                      (state_q == S_P2_RECOV) || (state_q == S_P2_READ) ||
                      (state_q == S_P2_PULSE);
        vpp_en      = vcc_prog_en;
    end

    assign host_addr = addr_q;
    assign dev_addr  = addr_q;
    assign done      = done_q;
    assign pass      = pass_q;
    assign fail_addr = fail_q;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
// Property checker for the programming sequencer, bound to every instance.
// Assumes the synchronous active-low reset of the sequencer.
module eprom_prog_seq_chk #(
    parameter int ADDR_W    = 16,
    parameter int PULSE_CYC = 25000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              host_req,
    input logic              host_valid,
    input logic [ADDR_W-1:0] host_addr,
    input logic              dev_pgm,
    input logic              dev_oe,
    input logic              vcc_prog_en,
    input logic              vpp_en
);

    logic [31:0] run_q;

    // Length of the current program pulse run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= dev_pgm ? run_q + 1 : 32'd0;
    end

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_pgm) |-> (run_q == 32'(PULSE_CYC)));

    // R3
    pulse_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pgm |-> (vcc_prog_en && vpp_en));

    // R3
    pulse_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_pgm && dev_oe));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_valid) |=> (host_req && $stable(host_addr)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .host_req    (host_req),
    .host_valid  (host_valid),
    .host_addr   (host_addr),
    .dev_pgm     (dev_pgm),
    .dev_oe      (dev_oe),
    .vcc_prog_en (vcc_prog_en),
    .vpp_en      (vpp_en)
);

// File: tb/tb_eprom_prog_seq.sv
`timescale 1ns/1ps
// Directed bench: a behavioural memory that needs a set number of pulses per
// word, a host that can stall, one task per scenario.
module tb_eprom_prog_seq;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int PULSE = 5;
    localparam int SETTLE = 4;
    localparam int RECOV = 2;
    localparam int RDC = 2;
    localparam int RETRY = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr, host_addr, dev_addr;
    logic          host_req, dev_oe, dev_pgm, vcc_prog_en, vpp_en;
    logic          host_valid = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic [DW-1:0] dev_wdata, dev_rdata;

    always #2 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE),
        .RECOV_CYC(RECOV), .READ_CYC(RDC), .MAX_RETRY(RETRY)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .host_req(host_req),
        .host_addr(host_addr), .host_valid(host_valid), .host_data(host_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_oe(dev_oe), .dev_pgm(dev_pgm), .vcc_prog_en(vcc_prog_en),
        .vpp_en(vpp_en)
    );

    // Memory and host model state.
    logic [DW-1:0] img   [NW];
    logic [DW-1:0] mem   [NW];
    logic [DW-1:0] drift [NW];
    int            need  [NW];
    int            pulses[NW];
    int            seq_log[64];
    int            n_log, stall_len, stall_cnt, logged;
    int            run_len, width_err, supply_err, data_err, oe_rises, low_reads;
    logic          pgm_prev, oe_prev;
    int            tests = 0;
    int            fails = 0;

    assign dev_rdata = dev_oe ? (mem[dev_addr] ^ (vcc_prog_en ? '0 : drift[dev_addr]))
                              : {DW{1'b1}};

    // Device and host model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (dev_pgm && !pgm_prev) begin
            pulses[dev_addr] = pulses[dev_addr] + 1;
            if (pulses[dev_addr] >= need[dev_addr]) mem[dev_addr] = dev_wdata;
            if (dev_wdata != img[dev_addr]) data_err = data_err + 1;
        end
        if (dev_pgm) begin
            run_len = run_len + 1;
            if (!(vcc_prog_en && vpp_en) || dev_oe) supply_err = supply_err + 1;
        end else if (pgm_prev) begin
            if (run_len != PULSE) width_err = width_err + 1;
            run_len = 0;
        end
        if (dev_oe && !oe_prev) begin
            oe_rises = oe_rises + 1;
            if (!vcc_prog_en && !vpp_en) low_reads = low_reads + 1;
        end
        if (host_valid) begin
            if (n_log < 64) seq_log[n_log] = logged;
            n_log = n_log + 1;
            host_valid = 1'b0;
        end else if (host_req) begin
            if (stall_cnt < stall_len) stall_cnt = stall_cnt + 1;
            else begin
                host_valid = 1'b1;
                host_data  = img[host_addr];
                logged     = int'(host_addr);
                stall_cnt  = 0;
            end
        end
        pgm_prev = dev_pgm;
        oe_prev  = dev_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_init(input int seed);
        for (int i = 0; i < NW; i++) begin
            img[i]    = DW'(16'h1234 + seed * 16'h0101 + i * 16'h0311);
            mem[i]    = {DW{1'b1}};
            drift[i]  = '0;
            need[i]   = 1;
            pulses[i] = 0;
        end
        n_log = 0; stall_len = 0; stall_cnt = 0; logged = 0; run_len = 0;
        width_err = 0; supply_err = 0; data_err = 0; oe_rises = 0; low_reads = 0;
    endtask

    // Start a run, check the supply settle, wait for done.
    task automatic run_seq();
        int wait_cyc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(done == 1'b0 && pass == 1'b0, "R10 done/pass cleared", {done, pass}, 0);
        check(vcc_prog_en && vpp_en, "R2 supplies raised", {vcc_prog_en, vpp_en}, 3);
        wait_cyc = 0;
        while (!host_req && wait_cyc < 1000) begin
            wait_cyc = wait_cyc + 1;
            @(negedge clk);
        end
        check(wait_cyc == SETTLE, "R2 settle before first request", wait_cyc, SETTLE);
        wait_cyc = 0;
        while (!done && wait_cyc < 20000) begin
            wait_cyc = wait_cyc + 1;
            @(negedge clk);
        end
        check(done == 1'b1 && busy == 1'b0, "R8 done and not busy", {done, busy}, 2);
    endtask

    task automatic check_order(input int n, input string tag);
        bit ok = (n_log == n);
        for (int i = 0; i < n && i < 64; i++)
            if (seq_log[i] != (i % NW)) ok = 0;
        check(ok, tag, n_log, n);
    endtask

    task automatic t_reset();
        check(!busy && !done && !pass && !host_req, "R1 idle status", {busy, done, pass, host_req}, 0);
        check(!dev_pgm && !dev_oe && !vcc_prog_en && !vpp_en, "R1 idle pins",
              {dev_pgm, dev_oe, vcc_prog_en, vpp_en}, 0);
    endtask

    task automatic t_clean();
        int bad = 0;
        model_init(1);
        run_seq();
        check(pass == 1'b1, "R8 clean run passes", pass, 1);
        for (int i = 0; i < NW; i++) if (pulses[i] != 1) bad = bad + 1;
        check(bad == 0, "R4 one pulse per word", bad, 0);
        check_order(3 * NW, "R4 R5 R7 request order over three sweeps");
        check(oe_rises == 2 * NW, "R4 no read in sweep 1", oe_rises, 2 * NW);
        check(low_reads == NW, "R7 final reads with supplies off", low_reads, NW);
        check(width_err == 0 && supply_err == 0, "R3 pulse width and supplies",
              width_err + supply_err, 0);
        check(data_err == 0, "R3 pulse data", data_err, 0);
        check(!vcc_prog_en && !vpp_en, "R7 supplies off at end", {vcc_prog_en, vpp_en}, 0);
    endtask

    task automatic t_retry();
        model_init(2);
        need[3] = 4;
        need[5] = RETRY + 1;
        run_seq();
        check(pulses[3] == 4, "R5 retry until match", pulses[3], 4);
        check(pulses[5] == RETRY + 1, "R5 match on last allowed pulse", pulses[5], RETRY + 1);
        check(pass == 1'b1, "R5 retried words pass", pass, 1);
        check(width_err == 0 && supply_err == 0, "R3 retry pulses", width_err + supply_err, 0);
    endtask

    task automatic t_exhaust();
        model_init(3);
        need[2] = RETRY + 2;
        run_seq();
        check(pass == 1'b0, "R6 exhausted word fails", pass, 0);
        check(fail_addr == 3'd2, "R6 fail address", int'(fail_addr), 2);
        check(pulses[2] == RETRY + 1, "R6 pulse count at limit", pulses[2], RETRY + 1);
        check(n_log == NW + 3, "R6 no further request", n_log, NW + 3);
        check(low_reads == 0, "R6 no final sweep", low_reads, 0);
        check(!vcc_prog_en && !vpp_en, "R6 supplies dropped", {vcc_prog_en, vpp_en}, 0);
    endtask

    task automatic t_final_miss();
        model_init(4);
        drift[6] = 16'h0010;
        run_seq();
        check(pass == 1'b0, "R7 final compare fails", pass, 0);
        check(fail_addr == 3'd6, "R7 fail address", int'(fail_addr), 6);
        check(low_reads == 7, "R7 final sweep stops at miss", low_reads, 7);
    endtask

    task automatic t_stall();
        model_init(5);
        stall_len = 3;
        run_seq();
        check(pass == 1'b1, "R9 stalled host passes", pass, 1);
        check(data_err == 0, "R9 word taken only when valid", data_err, 0);
        check_order(3 * NW, "R9 address order under stalls");
    endtask

    initial begin
        pgm_prev = 1'b0;
        oe_prev  = 1'b0;
        model_init(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_retry();
        t_exhaust();
        t_final_miss();
        t_stall();
        t_clean();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule